// File: doc/BRIEF.md
# Prioritized Interrupt Dispatch Controller

This controller collects interrupt requests from five sources for a small processor and hands the processor one vector address at a time. Each source has a bit in a flag register. A one-cycle request pulse on a source sets its flag bit, and software can also write the flag register. An enable register masks the sources. A master enable bit gates dispatch as a whole. Software turns the master enable on with an enable command and off with a disable command.

Dispatch is considered only in a cycle where the processor raises its instruction-boundary strobe. This keeps multi-byte instructions whole. When that strobe arrives, the master enable is on and some source is both flagged and enabled, the controller picks the lowest-numbered such source. It presents that source's vector and clears the master enable in the same clock edge. It holds the vector until the processor acknowledges it. The acknowledge clears only the serviced flag bit. An enable command is deliberately delayed: it takes hold only at the next instruction boundary, so the earliest dispatch after it is at the boundary after that one.

Top module: `irq_dispatch`

## Requirements
- R1: After reset no dispatch is presented (`irq_valid_o`=0), the enable register reads 0x00, the flag register reads 0xE0 and the master enable is off.
- R2: With `rd_sel_i`=0 `rd_data_o` shows all 8 stored enable bits. With `rd_sel_i`=1 it shows the five flag bits in bits 4:0, and bits 7:5 always read 1. A write with `wr_sel_i`=0 targets the enable register and one with `wr_sel_i`=1 targets the flags. Writes take effect at the next clock edge.
- R3: A source is a dispatch candidate only when its bit is 1 in both the enable register and the flag register. With no candidate, no dispatch occurs.
- R4: Source bits are 0 vertical blank, 1 display status, 2 timer, 3 serial and 4 keypad. Among candidates, the lowest bit number wins, and its vector is 0x40 + 8·n.
- R5: Dispatch starts only at a clock edge where `boundary_i` is 1 and the master enable is on. `irq_valid_o` rises after that edge.
- R6: At the dispatch edge the master enable is cleared. After the acknowledge, a boundary with candidates still pending starts no new dispatch.
- R7: After `ei_i`, the first following boundary only turns the master enable on and starts no dispatch. The boundary after that can dispatch.
- R8: `di_i` turns the master enable off, and it also cancels an enable command that has not yet taken hold.
- R9: An acknowledge (`irq_ack_i` while `irq_valid_o`=1) clears only the serviced source's flag bit and drops `irq_valid_o` at the next edge.
- R10: A request pulse sets its flag bit even when a flag write in the same cycle writes that bit to 0.
- R11: While `irq_valid_o` is 1 and not acknowledged, it stays 1 and `irq_vector_o` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 5 | Per-source request pulses |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 enable, 1 flag |
| wr_data_i | input | 8 | Write data |
| rd_sel_i | input | 1 | Read select: 0 enable, 1 flag |
| rd_data_o | output | 8 | Read data (combinational) |
| ei_i | input | 1 | Enable-interrupts command |
| di_i | input | 1 | Disable-interrupts command |
| boundary_i | input | 1 | Instruction-boundary strobe |
| irq_valid_o | output | 1 | Dispatch presented to the processor |
| irq_vector_o | output | 8 | Vector of the dispatched source |
| irq_ack_i | input | 1 | Processor accepts the dispatch |

## Verification
The assertions assume that `irq_ack_i` is raised only while a dispatch is presented. They also assume that `ei_i` and `di_i` are never raised together and that reset is held for at least one edge. The bench drives each command for exactly one cycle and acknowledges only after it has seen `irq_valid_o`. It sweeps every pairing of the five enable bits with the five flag bits. For each pairing it steps through the enable command and two boundaries, so that the delayed enable, the priority choice, the acknowledge clear and the cleared master enable are each checked.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic {SEL_ENABLE = 1'b0, SEL_FLAG = 1'b1} reg_sel_e;

  function automatic int vector_of(int base, int stride, int idx);
    return base + stride * idx;
  endfunction
endpackage

// File: rtl/irq_flag_reg.sv
module irq_flag_reg #(
  parameter int N     = 5,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [N-1:0]     wdata,
  input  logic [N-1:0]     req,
  input  logic             ack_en,
  input  logic [IDX_W-1:0] ack_idx,
  output logic [N-1:0]     flags
);
  logic [N-1:0] base_w;
  logic [N-1:0] clr_w;

  assign base_w = wr_en ? wdata : flags;
  assign clr_w  = ack_en ? (N'(1) << ack_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= (base_w & ~clr_w) | req;
  end

  a_r9_ack_clears_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_en && ((req & (N'(1) << ack_idx)) == '0)) |=> ((flags & (N'(1) << $past(ack_idx))) == '0));
  a_r10_request_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0) |=> ((flags & $past(req)) == $past(req)));
endmodule

// File: rtl/irq_master_en.sv
module irq_master_en (
  input  logic clk,
  input  logic rst_n,
  input  logic ei_cmd,
  input  logic di_cmd,
  input  logic boundary,
  input  logic dispatch,
  output logic ime
);
  logic arm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ime   <= 1'b0;
      arm_q <= 1'b0;
    end else if (dispatch) begin
      ime   <= 1'b0;
      arm_q <= 1'b0;
    end else if (di_cmd) begin
      ime   <= 1'b0;
      arm_q <= 1'b0;
    end else begin
      if (boundary && arm_q) begin
        ime   <= 1'b1;
        arm_q <= 1'b0;
      end
      if (ei_cmd) arm_q <= 1'b1;
    end
  end

  a_r6_clear_on_dispatch: assert property (@(posedge clk) disable iff (!rst_n)
    dispatch |=> !ime);
  a_r8_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    di_cmd |=> !ime);
  a_r7_enable_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ime) |-> $past(boundary));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int N     = 5,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     cand,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  logic [N-1:0] grant;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
        grant = N'(1) << i;
      end
    end
  end

  always_comb begin
    a_r4_single_grant: assert ($onehot0(grant));
    a_r4_grant_is_cand: assert ((grant & ~cand) == '0);
  end
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch #(
  parameter int NUM_SRC    = 5,
  parameter int REG_W      = 8,
  parameter int VEC_W      = 8,
  parameter int VEC_BASE   = 'h40,
  parameter int VEC_STRIDE = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               wr_en_i,
  input  logic               wr_sel_i,
  input  logic [REG_W-1:0]   wr_data_i,
  input  logic               rd_sel_i,
  output logic [REG_W-1:0]   rd_data_o,
  input  logic               ei_i,
  input  logic               di_i,
  input  logic               boundary_i,
  output logic               irq_valid_o,
  output logic [VEC_W-1:0]   irq_vector_o,
  input  logic               irq_ack_i
);
  import irq_pkg::*;

  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int PAD_W = REG_W - NUM_SRC;

  logic [REG_W-1:0]   ie_q;
  logic [NUM_SRC-1:0] flags_w;
  logic [NUM_SRC-1:0] cand_w;
  logic               found_w;
  logic [IDX_W-1:0]   win_idx_w;
  logic               ime_w;
  logic               dispatch_w;
  logic               ack_fire_w;
  logic               wr_ie_w;
  logic               wr_if_w;
  logic               valid_q;
  logic [IDX_W-1:0]   src_q;
  logic [VEC_W-1:0]   vec_q;

  assign wr_ie_w    = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_ENABLE);
  assign wr_if_w    = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_FLAG);
  assign cand_w     = ie_q[NUM_SRC-1:0] & flags_w;
  assign dispatch_w = boundary_i && ime_w && found_w && !valid_q;
  assign ack_fire_w = irq_ack_i && valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       ie_q <= '0;
    else if (wr_ie_w) ie_q <= wr_data_i;
  end

  irq_flag_reg #(.N(NUM_SRC), .IDX_W(IDX_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_if_w), .wdata(wr_data_i[NUM_SRC-1:0]),
    .req(req_i), .ack_en(ack_fire_w), .ack_idx(src_q), .flags(flags_w)
  );

  irq_arbiter #(.N(NUM_SRC), .IDX_W(IDX_W)) u_arb (
    .cand(cand_w), .found(found_w), .idx(win_idx_w)
  );

  irq_master_en u_ime (
    .clk(clk), .rst_n(rst_n), .ei_cmd(ei_i), .di_cmd(di_i),
    .boundary(boundary_i), .dispatch(dispatch_w), .ime(ime_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      src_q   <= '0;
      vec_q   <= '0;
    end else if (dispatch_w) begin
      valid_q <= 1'b1;
      src_q   <= win_idx_w;
      vec_q   <= VEC_W'(vector_of(VEC_BASE, VEC_STRIDE, int'(win_idx_w)));
    end else if (ack_fire_w) begin
      valid_q <= 1'b0;
    end
  end

  always_comb begin
    if (reg_sel_e'(rd_sel_i) == SEL_FLAG) rd_data_o = {{PAD_W{1'b1}}, flags_w};
    else                                  rd_data_o = ie_q;
  end

  assign irq_valid_o  = valid_q;
  assign irq_vector_o = vec_q;

  a_r5_start_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_q) |-> $past(boundary_i && ime_w));
  a_r3_dispatched_is_cand: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_q) |-> (($past(cand_w) & (NUM_SRC'(1) << src_q)) != '0));
  a_r11_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !irq_ack_i) |=> (valid_q && $stable(vec_q)));
  a_r9_ack_drops_valid: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire_w |=> !valid_q);
endmodule

// File: tb/irq_dispatch_bench.sv
module irq_dispatch_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] req_i = '0;
  logic       wr_en_i = 1'b0, wr_sel_i = 1'b0, rd_sel_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       ei_i = 1'b0, di_i = 1'b0, boundary_i = 1'b0, irq_ack_i = 1'b0;
  logic [7:0] rd_data_o, irq_vector_o;
  logic       irq_valid_o;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_dispatch u_irq_dispatch (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o), .ei_i(ei_i),
    .di_i(di_i), .boundary_i(boundary_i), .irq_valid_o(irq_valid_o),
    .irq_vector_o(irq_vector_o), .irq_ack_i(irq_ack_i)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(bit sel, logic [7:0] d);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    tick();
    wr_en_i = 1'b0;
  endtask

  function automatic logic [7:0] rd(bit sel);
    rd_sel_i = sel;
    return rd_data_o;
  endfunction

  task automatic read_chk(string tag, bit sel, int exp);
    rd_sel_i = sel;
    #1;
    check(tag, int'(rd_data_o), exp);
  endtask

  task automatic ei();   ei_i = 1'b1; tick(); ei_i = 1'b0; endtask
  task automatic di();   di_i = 1'b1; tick(); di_i = 1'b0; endtask
  task automatic bnd();  boundary_i = 1'b1; tick(); boundary_i = 1'b0; endtask
  task automatic ack();  irq_ack_i = 1'b1; tick(); irq_ack_i = 1'b0; endtask

  function automatic int lowest(int m);
    for (int i = 0; i < 5; i++) if (m[i]) return i;
    return -1;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    check("R1 valid", int'(irq_valid_o), 0);
    read_chk("R1 enable", 0, 'h00);
    read_chk("R1 flag", 1, 'hE0);
    wr(0, 8'h1F); wr(1, 8'h01);
    bnd(); bnd();
    check("R1 ime off", int'(irq_valid_o), 0);

    // R2 readback
    wr(0, 8'hFF); read_chk("R2 enable ff", 0, 'hFF);
    wr(0, 8'hA5); read_chk("R2 enable a5", 0, 'hA5);
    wr(1, 8'hFF); read_chk("R2 flag ff", 1, 'hFF);
    wr(1, 8'h0A); read_chk("R2 flag 0a", 1, 'hEA);

    // R10 request beats write
    req_i = 5'b00100; wr(1, 8'h00); req_i = '0;
    read_chk("R10 req wins", 1, 'hE4);
    req_i = 5'b10000; tick(); req_i = '0;
    read_chk("R10 req keeps others", 1, 'hF4);

    // R5 no dispatch without boundary
    wr(0, 8'h1F); wr(1, 8'h08); ei(); bnd();
    for (int k = 0; k < 5; k++) tick();
    check("R5 no boundary", int'(irq_valid_o), 0);
    bnd();
    check("R5 boundary dispatch", int'(irq_valid_o), 1);
    check("R4 vec serial", int'(irq_vector_o), 'h58);
    // R11 hold
    for (int k = 0; k < 4; k++) tick();
    check("R11 hold valid", int'(irq_valid_o), 1);
    check("R11 hold vec", int'(irq_vector_o), 'h58);
    ack();
    check("R9 valid drop", int'(irq_valid_o), 0);

    // R8 disable
    wr(1, 8'h01); ei(); bnd(); di(); bnd();
    check("R8 di blocks", int'(irq_valid_o), 0);
    ei(); di(); bnd(); bnd();
    check("R8 di cancels pending ei", int'(irq_valid_o), 0);

    // Sweep R3 R4 R6 R7 R9
    for (int ie = 0; ie < 32; ie++) begin
      for (int fl = 0; fl < 32; fl++) begin
        int m;
        int n;
        m = ie & fl;
        n = lowest(m);
        wr(0, 8'(ie)); wr(1, 8'(fl));
        ei(); bnd();
        check("R7 first boundary", int'(irq_valid_o), 0);
        bnd();
        if (m != 0) begin
          check("R3 R4 valid", int'(irq_valid_o), 1);
          check("R4 vector", int'(irq_vector_o), 'h40 + 8 * n);
          ack();
          check("R9 valid low", int'(irq_valid_o), 0);
          read_chk("R9 flag clear", 1, (fl & ~(1 << n)) | 'hE0);
          bnd();
          check("R6 ime cleared", int'(irq_valid_o), 0);
        end else begin
          check("R3 no cand", int'(irq_valid_o), 0);
          di();
        end
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule